// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block performs the architectural state changes a 32-bit core makes when it enters an exception. The core presents a request with a two-bit cause and a snapshot of its current state. The state is the PC, the active and kernel stack pointers, the condition-code stack word, the exception base, the core version and the delay-slot count. The block then steps through a fixed sequence:

- select the handler vector and save the return address into the exception or NMI return register;
- write the exception-status index and update the condition-code stack word;
- swap stack pointers when the core was in user mode;
- read the handler address from memory and load it into the PC.

Two entry flows exist, chosen by the core version. The current flow rewinds the return address over a pending delay slot, writes the status index and applies the nested condition-code shift. The legacy flow, taken when the version is below a limit, skips those three steps, sets an interrupt-lock flag, and reports a bus fault as an error instead of entering a handler.

Every register update leaves the block as a one-cycle write strobe with its value. The handler fetch uses a valid/ready request channel and a response channel that may stall for any number of cycles.

Top module: `exc_entry_seq`

## Requirements
- R1: The cause code on `req_cause` selects the vector. Code 0 is a software break and uses `trap_vec`. Code 1 is an NMI and uses vector 0. Code 2 is a bus fault and uses `fault_vec`. Code 3 is an external interrupt and uses `irq_vec`.
- R2: Codes 0, 2 and 3 pulse `erp_we` and not `nrp_we`. Code 1 pulses `nrp_we` and not `erp_we`, and it clears bit 30 (M) of the condition-code word. The return value on `ret_addr` is based on `cur_pc`.
- R3: In the current flow, `exs_we` pulses with `exs_val` holding the low 8 vector bits in bits 15:8 and zero in every other bit.
- R4: In the current flow, a nonzero `dslot_cnt` is subtracted from the saved return address and `dslot_clr` pulses. A zero count leaves the address unchanged and does not pulse `dslot_clr`.
- R5: If bit 8 (U) of `ccs_in` is set, `usp_we` and `sp_we` pulse together one cycle after the return-address write. `usp_val` equals `cur_sp` and `sp_val` equals `kern_sp`. If U is clear, neither pulses.
- R6: In the current flow, `ccs_we` pulses with `ccs_val` = {c[31:30], c[19:0], 10'b0}. Here c is `ccs_in` after any M clear from R2.
- R7: `rd_valid` is raised with `rd_addr` = `ebase` + 4 × vector, held stable until `rd_ready`, and issued exactly once. The word returned with `rsp_valid`, after any number of wait cycles, appears on `pc_val` with a one-cycle `pc_we`.
- R8: When `core_ver` < 32 (legacy flow), `exs_we` and `dslot_clr` stay low and no delay-slot rewind is applied. `ccs_we` pulses only for an NMI, carrying `ccs_in` with M cleared and no shift. `irq_lock_set` pulses together with `pc_we`. A version of 32 or above takes the current flow and never pulses `irq_lock_set`.
- R9: A legacy-flow bus fault pulses `entry_err` for one cycle in the cycle after acceptance. It produces no return, status, stack, read or PC activity, and the block returns to idle.
- R10: `busy` is low after reset and rises in the cycle after a request is accepted. It stays high until the cycle with `pc_we` (or `entry_err`). Requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request, accepted when idle |
| req_cause | input | 2 | Cause code (R1 encoding) |
| trap_vec | input | VEC_W | Vector for software break |
| fault_vec | input | VEC_W | Vector latched for a bus fault |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| cur_pc | input | XLEN | PC at the time of the request |
| cur_sp | input | XLEN | Active stack pointer |
| kern_sp | input | XLEN | Kernel stack pointer |
| ccs_in | input | XLEN | Condition-code stack word |
| ebase | input | XLEN | Exception vector table base |
| core_ver | input | VER_W | Core version value |
| dslot_cnt | input | DSLOT_W | Delay-slot count |
| busy | output | 1 | Entry sequence in progress |
| erp_we | output | 1 | Write exception return register |
| nrp_we | output | 1 | Write NMI return register |
| ret_addr | output | XLEN | Return address value |
| exs_we | output | 1 | Write exception-status register |
| exs_val | output | XLEN | Exception-status value |
| ccs_we | output | 1 | Write condition-code stack word |
| ccs_val | output | XLEN | New condition-code stack word |
| dslot_clr | output | 1 | Clear the delay-slot count |
| usp_we | output | 1 | Write user stack pointer |
| usp_val | output | XLEN | New user stack pointer |
| sp_we | output | 1 | Write active stack pointer |
| sp_val | output | XLEN | New active stack pointer |
| rd_valid | output | 1 | Handler read request valid |
| rd_ready | input | 1 | Handler read request accepted |
| rd_addr | output | XLEN | Handler read address |
| rsp_valid | input | 1 | Handler read data valid |
| rsp_data | input | XLEN | Handler read data |
| pc_we | output | 1 | Load new PC |
| pc_val | output | XLEN | New PC (handler address) |
| irq_lock_set | output | 1 | Set interrupt lock (legacy flow) |
| entry_err | output | 1 | Illegal legacy bus fault |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit vectors, a 2-bit delay-slot count, an 8-bit version with the legacy limit at 32, and the legacy flow present. With these values the version boundary can be probed on both sides, at 31 and 32. The largest vector, 0xFF, exercises the top table offset 0x3FC and a fully populated status index. The largest delay-slot count, 3, rewinds the return address to its furthest point. Read-request and response stalls of several cycles are mixed with zero-wait fetches, and a request injected mid-sequence probes the busy interlock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      CAUSE_BREAK    = 2'd0,
      CAUSE_NMI      = 2'd1,
      CAUSE_BUSFAULT = 2'd2,
      CAUSE_IRQ      = 2'd3
   } exc_cause_e;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_SAVE       = 3'd1,
      ST_SWAP       = 3'd2,
      ST_FETCH_REQ  = 3'd3,
      ST_FETCH_WAIT = 3'd4,
      ST_DONE       = 3'd5
   } seq_state_e;

endpackage

// File: rtl/exc_vec_route.sv
module exc_vec_route
   import exc_entry_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic [1:0]       cause_i,
   input  logic [VEC_W-1:0] trap_vec_i,
   input  logic [VEC_W-1:0] fault_vec_i,
   input  logic [VEC_W-1:0] irq_vec_i,
   output logic [VEC_W-1:0] vec_o,
   output logic             to_nrp_o,
   output logic             is_bus_o
);

   always_comb begin
      vec_o    = irq_vec_i;
      to_nrp_o = 1'b0;
      is_bus_o = 1'b0;
      unique case (exc_cause_e'(cause_i))
         CAUSE_BREAK: vec_o = trap_vec_i;
         CAUSE_NMI: begin
            vec_o    = '0;
            to_nrp_o = 1'b1;
         end
         CAUSE_BUSFAULT: begin
            vec_o    = fault_vec_i;
            is_bus_o = 1'b1;
         end
         default: vec_o = irq_vec_i;
      endcase
   end

endmodule

// File: rtl/exc_ccs_next.sv
module exc_ccs_next #(
   parameter int XLEN    = 32,
   parameter int KEEP_HI = 2,
   parameter int SHIFT   = 10,
   parameter int M_BIT   = 30
) (
   input  logic [XLEN-1:0] ccs_i,
   input  logic            clr_m_i,
   input  logic            nest_i,
   output logic [XLEN-1:0] ccs_o
);

   localparam int MID = XLEN - KEEP_HI - SHIFT;
   localparam logic [XLEN-1:0] M_MASK = XLEN'(1) << M_BIT;

   if (MID < 1 || KEEP_HI < 1 || SHIFT < 1) begin : g_bad_geom
      $error("exc_ccs_next: KEEP_HI + SHIFT must leave room inside XLEN");
   end
   if (M_BIT < 0 || M_BIT >= XLEN) begin : g_bad_m
      $error("exc_ccs_next: M_BIT out of range");
   end

   logic [XLEN-1:0] masked;
   logic [XLEN-1:0] nested;

   assign masked = clr_m_i ? (ccs_i & ~M_MASK) : ccs_i;
   assign nested = {masked[XLEN-1 -: KEEP_HI], masked[MID-1:0], {SHIFT{1'b0}}};
   assign ccs_o  = nest_i ? nested : masked;

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
   import exc_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       abort_i,
   input  logic       rd_ready_i,
   input  logic       rsp_valid_i,
   output seq_state_e state_o
);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:       if (start_i) state_d = ST_SAVE;
         ST_SAVE:       state_d = abort_i ? ST_IDLE : ST_SWAP;
         ST_SWAP:       state_d = ST_FETCH_REQ;
         ST_FETCH_REQ:  if (rd_ready_i) state_d = ST_FETCH_WAIT;
         ST_FETCH_WAIT: if (rsp_valid_i) state_d = ST_DONE;
         ST_DONE:       state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int VEC_W        = 8,
   parameter int DSLOT_W      = 2,
   parameter int VER_W        = 8,
   parameter int LEGACY_LIMIT = 32,
   parameter bit HAS_LEGACY   = 1'b1,
   parameter int CCS_KEEP_HI  = 2,
   parameter int CCS_SHIFT    = 10,
   parameter int M_BIT        = 30,
   parameter int U_BIT        = 8,
   parameter int EXS_IDX_LSB  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_cause,
   input  logic [VEC_W-1:0]   trap_vec,
   input  logic [VEC_W-1:0]   fault_vec,
   input  logic [VEC_W-1:0]   irq_vec,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    cur_sp,
   input  logic [XLEN-1:0]    kern_sp,
   input  logic [XLEN-1:0]    ccs_in,
   input  logic [XLEN-1:0]    ebase,
   input  logic [VER_W-1:0]   core_ver,
   input  logic [DSLOT_W-1:0] dslot_cnt,
   output logic               busy,
   output logic               erp_we,
   output logic               nrp_we,
   output logic [XLEN-1:0]    ret_addr,
   output logic               exs_we,
   output logic [XLEN-1:0]    exs_val,
   output logic               ccs_we,
   output logic [XLEN-1:0]    ccs_val,
   output logic               dslot_clr,
   output logic               usp_we,
   output logic [XLEN-1:0]    usp_val,
   output logic               sp_we,
   output logic [XLEN-1:0]    sp_val,
   output logic               rd_valid,
   input  logic               rd_ready,
   output logic [XLEN-1:0]    rd_addr,
   input  logic               rsp_valid,
   input  logic [XLEN-1:0]    rsp_data,
   output logic               pc_we,
   output logic [XLEN-1:0]    pc_val,
   output logic               irq_lock_set,
   output logic               entry_err
);

   localparam int IDX_W     = 8;
   localparam int VEC_SCALE = 2;

   if (EXS_IDX_LSB + IDX_W > XLEN) begin : g_bad_exs
      $error("exc_entry_seq: status index field does not fit XLEN");
   end
   if (VEC_W < 1 || VEC_W + VEC_SCALE > XLEN) begin : g_bad_vec
      $error("exc_entry_seq: VEC_W out of range");
   end
   if (DSLOT_W < 1 || DSLOT_W >= XLEN) begin : g_bad_dslot
      $error("exc_entry_seq: DSLOT_W out of range");
   end
   if (U_BIT < 0 || U_BIT >= XLEN) begin : g_bad_u
      $error("exc_entry_seq: U_BIT out of range");
   end
   if (HAS_LEGACY && (LEGACY_LIMIT < 1 || LEGACY_LIMIT >= (1 << VER_W))) begin : g_bad_ver
      $error("exc_entry_seq: LEGACY_LIMIT does not fit VER_W");
   end

   // ---------------------------------------------------------------
   // Sequencer state
   // ---------------------------------------------------------------
   seq_state_e state;
   logic       accept;
   logic       abort;

   // ---------------------------------------------------------------
   // Request decode (combinational, from the request-time inputs)
   // ---------------------------------------------------------------
   logic [VEC_W-1:0] vec_now;
   logic             nrp_now;
   logic             bus_now;
   logic             legacy_now;
   logic [XLEN-1:0]  ret_now;
   logic [XLEN-1:0]  ccs_now;

   exc_vec_route #(
      .VEC_W (VEC_W)
   ) u_route (
      .cause_i     (req_cause),
      .trap_vec_i  (trap_vec),
      .fault_vec_i (fault_vec),
      .irq_vec_i   (irq_vec),
      .vec_o       (vec_now),
      .to_nrp_o    (nrp_now),
      .is_bus_o    (bus_now)
   );

   if (HAS_LEGACY) begin : g_legacy
      assign legacy_now = (core_ver < VER_W'(LEGACY_LIMIT));
   end else begin : g_no_legacy
      assign legacy_now = 1'b0;
   end

   assign ret_now = legacy_now ? cur_pc : (cur_pc - XLEN'(dslot_cnt));

   exc_ccs_next #(
      .XLEN    (XLEN),
      .KEEP_HI (CCS_KEEP_HI),
      .SHIFT   (CCS_SHIFT),
      .M_BIT   (M_BIT)
   ) u_ccs (
      .ccs_i   (ccs_in),
      .clr_m_i (nrp_now),
      .nest_i  (!legacy_now),
      .ccs_o   (ccs_now)
   );

   // ---------------------------------------------------------------
   // Snapshot of the request, captured on acceptance
   // ---------------------------------------------------------------
   logic [VEC_W-1:0] s_vec;
   logic             s_nrp;
   logic             s_bus;
   logic             s_legacy;
   logic             s_user;
   logic             s_dslot_nz;
   logic [XLEN-1:0]  s_ret;
   logic [XLEN-1:0]  s_ccs;
   logic [XLEN-1:0]  s_sp;
   logic [XLEN-1:0]  s_ksp;
   logic [XLEN-1:0]  s_ebase;
   logic [XLEN-1:0]  s_handler;

   assign accept = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vec      <= '0;
         s_nrp      <= 1'b0;
         s_bus      <= 1'b0;
         s_legacy   <= 1'b0;
         s_user     <= 1'b0;
         s_dslot_nz <= 1'b0;
         s_ret      <= '0;
         s_ccs      <= '0;
         s_sp       <= '0;
         s_ksp      <= '0;
         s_ebase    <= '0;
      end else if (accept) begin
         s_vec      <= vec_now;
         s_nrp      <= nrp_now;
         s_bus      <= bus_now;
         s_legacy   <= legacy_now;
         s_user     <= ccs_in[U_BIT];
         s_dslot_nz <= (dslot_cnt != '0);
         s_ret      <= ret_now;
         s_ccs      <= ccs_now;
         s_sp       <= cur_sp;
         s_ksp      <= kern_sp;
         s_ebase    <= ebase;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          s_handler <= '0;
      else if (state == ST_FETCH_WAIT && rsp_valid)        s_handler <= rsp_data;
   end

   assign abort = (state == ST_SAVE) && s_legacy && s_bus;

   exc_entry_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .abort_i     (abort),
      .rd_ready_i  (rd_ready),
      .rsp_valid_i (rsp_valid),
      .state_o     (state)
   );

   // ---------------------------------------------------------------
   // Write strobes and values
   // ---------------------------------------------------------------
   logic             in_save;
   logic [IDX_W-1:0] idx;

   assign in_save = (state == ST_SAVE);
   assign idx     = IDX_W'(s_vec);

   assign busy      = (state != ST_IDLE);
   assign erp_we    = in_save && !abort && !s_nrp;
   assign nrp_we    = in_save && s_nrp;
   assign ret_addr  = s_ret;
   assign exs_we    = in_save && !s_legacy;
   assign exs_val   = XLEN'(idx) << EXS_IDX_LSB;
   assign ccs_we    = in_save && !abort && (!s_legacy || s_nrp);
   assign ccs_val   = s_ccs;
   assign dslot_clr = in_save && !s_legacy && s_dslot_nz;

   assign usp_we  = (state == ST_SWAP) && s_user;
   assign sp_we   = (state == ST_SWAP) && s_user;
   assign usp_val = s_sp;
   assign sp_val  = s_ksp;

   assign rd_valid = (state == ST_FETCH_REQ);
   assign rd_addr  = s_ebase + (XLEN'(s_vec) << VEC_SCALE);

   assign pc_we        = (state == ST_DONE);
   assign pc_val       = s_handler;
   assign irq_lock_set = (state == ST_DONE) && s_legacy;
   assign entry_err    = abort;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int XLEN        = 32,
   parameter int CCS_SHIFT   = 10,
   parameter int EXS_IDX_LSB = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            busy,
   input logic            erp_we,
   input logic            nrp_we,
   input logic            exs_we,
   input logic [XLEN-1:0] exs_val,
   input logic            ccs_we,
   input logic [XLEN-1:0] ccs_val,
   input logic            usp_we,
   input logic            rd_valid,
   input logic            rd_ready,
   input logic [XLEN-1:0] rd_addr,
   input logic            pc_we,
   input logic            irq_lock_set,
   input logic            entry_err
);

   localparam logic [XLEN-1:0] EXS_MASK = XLEN'(8'hFF) << EXS_IDX_LSB;
   localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << CCS_SHIFT) - XLEN'(1);

   AST_RET_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erp_we, nrp_we})); // R2

   AST_EXS_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      exs_we |-> ((exs_val & ~EXS_MASK) == '0)); // R3

   AST_SWAP_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      usp_we |-> $past(erp_we || nrp_we)); // R5

   AST_CCS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ccs_we && exs_we) |-> ((ccs_val & LOW_MASK) == '0)); // R6

   AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R7

   AST_LOCK_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lock_set |-> pc_we); // R8

   AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      entry_err |=> (!busy && !rd_valid)); // R9

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy); // R10

   AST_PC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> busy); // R10

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
   .XLEN        (XLEN),
   .CCS_SHIFT   (CCS_SHIFT),
   .EXS_IDX_LSB (EXS_IDX_LSB)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .busy         (busy),
   .erp_we       (erp_we),
   .nrp_we       (nrp_we),
   .exs_we       (exs_we),
   .exs_val      (exs_val),
   .ccs_we       (ccs_we),
   .ccs_val      (ccs_val),
   .usp_we       (usp_we),
   .rd_valid     (rd_valid),
   .rd_ready     (rd_ready),
   .rd_addr      (rd_addr),
   .pc_we        (pc_we),
   .irq_lock_set (irq_lock_set),
   .entry_err    (entry_err)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_cause = 2'd0;
   logic [7:0]  trap_vec = '0, fault_vec = '0, irq_vec = '0;
   logic [31:0] cur_pc = '0, cur_sp = '0, kern_sp = '0, ccs_in = '0, ebase = '0;
   logic [7:0]  core_ver = 8'd32;
   logic [1:0]  dslot_cnt = '0;
   logic        busy, erp_we, nrp_we, exs_we, ccs_we, dslot_clr, usp_we, sp_we;
   logic [31:0] ret_addr, exs_val, ccs_val, usp_val, sp_val, rd_addr, pc_val;
   logic        rd_valid, rd_ready = 1'b0, rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic        pc_we, irq_lock_set, entry_err;

   exc_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
      .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
      .cur_pc(cur_pc), .cur_sp(cur_sp), .kern_sp(kern_sp), .ccs_in(ccs_in),
      .ebase(ebase), .core_ver(core_ver), .dslot_cnt(dslot_cnt),
      .busy(busy), .erp_we(erp_we), .nrp_we(nrp_we), .ret_addr(ret_addr),
      .exs_we(exs_we), .exs_val(exs_val), .ccs_we(ccs_we), .ccs_val(ccs_val),
      .dslot_clr(dslot_clr), .usp_we(usp_we), .usp_val(usp_val),
      .sp_we(sp_we), .sp_val(sp_val), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pc_we(pc_we), .pc_val(pc_val), .irq_lock_set(irq_lock_set),
      .entry_err(entry_err)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // observations of one entry sequence
   int          o_erp, o_nrp, o_exs, o_ccs, o_dclr, o_usp, o_sp, o_rd, o_pc, o_lock, o_err;
   int          k_save, k_swap;
   bit          rd_moved;
   logic [31:0] v_ret, v_exs, v_ccs, v_usp, v_sp, v_rd, v_pc;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog expired act=%0d exp<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] nest(input logic [31:0] c);
      return {c[31:30], c[19:0], 10'b0};
   endfunction

   // Issue one request (inputs already set) and follow it to the end.
   task automatic run_seq(input int rdy_dly, input int rsp_dly,
                          input logic [31:0] handler, input bit inject);
      bit hs = 0;
      int waited = 0;
      int rcnt = 0;
      o_erp = 0; o_nrp = 0; o_exs = 0; o_ccs = 0; o_dclr = 0; o_usp = 0;
      o_sp = 0; o_rd = 0; o_pc = 0; o_lock = 0; o_err = 0;
      k_save = -1; k_swap = -1; rd_moved = 0;
      v_ret = '0; v_exs = '0; v_ccs = '0; v_usp = '0; v_sp = '0; v_rd = '0; v_pc = '0;
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (!busy) break;
         if (erp_we)    begin o_erp++; v_ret = ret_addr; k_save = k; end
         if (nrp_we)    begin o_nrp++; v_ret = ret_addr; k_save = k; end
         if (exs_we)    begin o_exs++; v_exs = exs_val; end
         if (ccs_we)    begin o_ccs++; v_ccs = ccs_val; end
         if (dslot_clr) o_dclr++;
         if (usp_we)    begin o_usp++; v_usp = usp_val; k_swap = k; end
         if (sp_we)     begin o_sp++;  v_sp = sp_val; end
         if (pc_we)     begin o_pc++;  v_pc = pc_val; end
         if (irq_lock_set) o_lock++;
         if (entry_err) o_err++;
         if (rd_valid) begin
            if (waited == 0) v_rd = rd_addr;
            else if (rd_addr !== v_rd) rd_moved = 1;
         end
         // second request while busy
         if (inject && k == 1) begin
            req_cause = 2'd0;
            trap_vec  = 8'h7E;
            req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         rsp_valid = 1'b0;
         if (hs) begin
            if (rcnt == rsp_dly) begin
               rsp_valid = 1'b1;
               rsp_data  = handler;
               hs = 0;
            end
            rcnt++;
         end
         if (rd_valid) begin
            waited++;
            if (waited > rdy_dly) begin
               rd_ready = 1'b1;
               o_rd++;
               hs = 1;
            end else begin
               rd_ready = 1'b0;
            end
         end else begin
            rd_ready = 1'b0;
         end
      end
      rd_ready = 1'b0;
      rsp_valid = 1'b0;
      req_valid = 1'b0;
   endtask

   task automatic set_state(input logic [1:0] cause, input logic [31:0] pc,
                            input logic [31:0] ccs, input logic [7:0] ver,
                            input logic [1:0] ds);
      req_cause = cause;
      cur_pc    = pc;
      ccs_in    = ccs;
      core_ver  = ver;
      dslot_cnt = ds;
      cur_sp    = 32'h1111_0F00;
      kern_sp   = 32'h2222_0800;
      ebase     = 32'h0000_8000;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 busy after reset", {31'b0, busy}, 32'd0);
      chk("R7 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
      chk("R10 pc_we after reset", {31'b0, pc_we}, 32'd0);
   endtask

   task automatic t_break_user();
      trap_vec = 8'h21;
      set_state(2'd0, 32'h4000_1000, 32'h8000_0134, 8'd32, 2'd0);
      run_seq(0, 0, 32'hC000_1234, 0);
      chk("R2 break erp count", o_erp, 1);
      chk("R2 break nrp count", o_nrp, 0);
      chk("R2 break ret", v_ret, 32'h4000_1000);
      chk("R3 break exs", v_exs, 32'h0000_2100);
      chk("R6 break ccs", v_ccs, nest(32'h8000_0134));
      chk("R4 zero dslot no clear", o_dclr, 0);
      chk("R5 usp value", v_usp, 32'h1111_0F00);
      chk("R5 sp value", v_sp, 32'h2222_0800);
      chk("R5 swap cycle after save", k_swap, k_save + 1);
      chk("R1 break fetch addr", v_rd, 32'h0000_8084);
      chk("R7 pc value", v_pc, 32'hC000_1234);
      chk("R8 no lock at ver 32", o_lock, 0);
   endtask

   task automatic t_nmi_dslot();
      set_state(2'd1, 32'h0001_0010, 32'h4005_A021, 8'd40, 2'd2);
      run_seq(2, 1, 32'hC000_0000, 0);
      chk("R2 nmi nrp count", o_nrp, 1);
      chk("R2 nmi erp count", o_erp, 0);
      chk("R4 nmi rewind", v_ret, 32'h0001_000E);
      chk("R4 dslot clear", o_dclr, 1);
      chk("R1 nmi vector 0 addr", v_rd, 32'h0000_8000);
      chk("R3 nmi exs", v_exs, 32'h0);
      chk("R6 R2 nmi ccs", v_ccs, nest(32'h0005_A021));
      chk("R5 no swap", o_usp + o_sp, 0);
   endtask

   task automatic t_bus_stall();
      fault_vec = 8'hFF;
      set_state(2'd2, 32'h2000_0400, 32'h0000_0000, 8'd200, 2'd3);
      run_seq(3, 5, 32'hABCD_0123, 0);
      chk("R4 bus rewind max", v_ret, 32'h2000_03FD);
      chk("R3 bus exs max", v_exs, 32'h0000_FF00);
      chk("R1 bus fetch addr", v_rd, 32'h0000_83FC);
      chk("R7 single read", o_rd, 1);
      chk("R7 addr held", {31'b0, rd_moved}, 32'd0);
      chk("R7 pc after stalls", v_pc, 32'hABCD_0123);
      chk("R7 pc_we once", o_pc, 1);
   endtask

   task automatic t_irq_busy();
      irq_vec = 8'h40;
      set_state(2'd3, 32'h0000_5000, 32'h0000_0000, 8'd255, 2'd0);
      run_seq(1, 2, 32'h1234_5678, 1);
      chk("R1 irq fetch addr", v_rd, 32'h0000_8100);
      chk("R10 one pc write", o_pc, 1);
      chk("R10 one read", o_rd, 1);
      chk("R10 ignored req save", o_erp, 1);
      repeat (3) begin
         @(negedge clk);
         chk("R10 idle after ignored req", {31'b0, busy}, 32'd0);
      end
   endtask

   task automatic t_legacy_irq();
      irq_vec = 8'h12;
      set_state(2'd3, 32'h0000_7000, 32'h0000_0100, 8'd31, 2'd3);
      run_seq(0, 0, 32'h5555_AAAA, 0);
      chk("R8 legacy no rewind", v_ret, 32'h0000_7000);
      chk("R8 legacy no exs", o_exs, 0);
      chk("R8 legacy no ccs", o_ccs, 0);
      chk("R8 legacy no dslot clr", o_dclr, 0);
      chk("R8 legacy lock", o_lock, 1);
      chk("R5 legacy swap", o_usp, 1);
      chk("R7 legacy pc", v_pc, 32'h5555_AAAA);
   endtask

   task automatic t_legacy_nmi();
      set_state(2'd1, 32'h0000_9000, 32'h4000_0F0F, 8'd0, 2'd1);
      run_seq(0, 0, 32'h0BAD_F00D, 0);
      chk("R8 legacy nmi ccs unshifted", v_ccs, 32'h0000_0F0F);
      chk("R2 legacy nmi nrp", o_nrp, 1);
      chk("R8 legacy nmi ret", v_ret, 32'h0000_9000);
   endtask

   task automatic t_legacy_bus();
      fault_vec = 8'h05;
      set_state(2'd2, 32'h0000_A000, 32'h0000_0100, 8'd10, 2'd0);
      run_seq(0, 0, 32'h0, 0);
      chk("R9 err pulse", o_err, 1);
      chk("R9 no return write", o_erp + o_nrp, 0);
      chk("R9 no read", o_rd, 0);
      chk("R9 no pc", o_pc, 0);
      chk("R9 no swap", o_usp, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_break_user();
      t_nmi_dslot();
      t_bus_stall();
      t_irq_busy();
      t_legacy_irq();
      t_legacy_nmi();
      t_legacy_bus();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule